// File: doc/BRIEF.md
# Bidirectional Barrel Shifter with Bit-Reversal Wrapping

This block moves a 16-bit operand left or right by a count of zero to fifteen places. It has no clock: the result follows the inputs combinationally. It is meant to sit beside an adder and a bitwise logic unit inside an ALU. Its function code selects one of three operations: a left shift, a right shift that brings in zeros, or a right shift that copies the operand's top bit into every vacated place.

The datapath contains only left-moving stages. There are four of them, moving by one, two, four and eight places. Each stage is enabled by one bit of the count. A right shift reverses the operand's bit order before the stages and reverses the stage output again afterwards. The whole path is therefore six 16-bit two-way selections deep, whatever the direction. A single fill bit feeds every stage. It is the operand's sign bit for an arithmetic right shift and zero for all other operations.

Top module: `reversing_shifter`

## Requirements
- R1: With `shift_mode` = 2'b00, `result` equals `operand_a` moved left by `operand_b[3:0]` places, with zeros in the vacated low bits.
- R2: With `shift_mode` = 2'b01, `result` equals `operand_a` moved right by `operand_b[3:0]` places, with zeros in the vacated high bits.
- R3: With `shift_mode` = 2'b11, `result` equals `operand_a` moved right by `operand_b[3:0]` places, with every vacated high bit equal to `operand_a[15]`.
- R4: `operand_b[15:4]` has no effect on `result` in any mode.
- R5: A count of zero returns `operand_a` unchanged in all four modes.
- R6: In mode 2'b11 with a count of 15, all sixteen bits of `result` equal `operand_a[15]`.
- R7: `shift_mode` = 2'b10 gives the same result as 2'b00, which is a zero-filling left shift.
- R8: `result` settles from the inputs with no clock, so a new input combination yields its result without waiting for any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_a | input | 16 | Value to be shifted |
| operand_b | input | 16 | Bits 3:0 give the shift count; bits 15:4 are unused |
| shift_mode | input | 2 | Bit 0 selects the right direction; bit 1, together with bit 0, selects sign fill |
| result | output | 16 | Shifted value |

## Verification
The bench sweeps every count in every mode over operands that include alternating patterns, single set bits at each end, all ones, and values with the sign bit both set and clear. This exposes a fill bit that leaks into a left or logical-right shift, or a sign fill that uses the wrong bit. It also exposes a missing reversal on either side, which would return a left shift mirrored or leave the data bit-reversed. The high bits of the count operand are driven with noise. A stage wired to the wrong count bit, or a count decoded from more than four bits, would then change the result. Mode 2'b10 is compared against a plain left shift, because a decoder that treated bit 1 alone as "arithmetic" would sign-fill there.

// File: rtl/shifter_pkg.sv
package shifter_pkg;

    localparam int unsigned SHF_WIDTH = 16;

    typedef enum logic [1:0] {
        MODE_SHL     = 2'b00,
        MODE_SHR_LOG = 2'b01,
        MODE_SHL_ALT = 2'b10,
        MODE_SHR_ART = 2'b11
    } shift_mode_e;

    typedef struct packed {
        logic reverse;
        logic fill;
    } shift_ctrl_t;

endpackage

// File: rtl/bit_reverse_stage.sv
module bit_reverse_stage #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             enable,
    input  logic [WIDTH-1:0] data_in,
    output logic [WIDTH-1:0] data_out
);

    logic [WIDTH-1:0] mirrored_d;

    for (genvar i = 0; i < WIDTH; i++) begin : g_mirror
        assign mirrored_d[i] = data_in[WIDTH-1-i];
    end

    always_comb begin
        data_out = enable ? mirrored_d : data_in;
    end

endmodule

// File: rtl/left_shift_stage.sv
module left_shift_stage #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned DIST  = 1
) (
    input  logic             enable,
    input  logic             fill,
    input  logic [WIDTH-1:0] data_in,
    output logic [WIDTH-1:0] data_out
);

    logic [WIDTH-1:0] moved_d;

    if (DIST < WIDTH) begin : g_partial
        assign moved_d = {data_in[WIDTH-1-DIST:0], {DIST{fill}}};
    end else begin : g_full
        assign moved_d = {WIDTH{fill}};
    end

    always_comb begin
        data_out = enable ? moved_d : data_in;
    end

endmodule

// File: rtl/reversing_shifter.sv
module reversing_shifter
    import shifter_pkg::*;
#(
    parameter int unsigned WIDTH = SHF_WIDTH
) (
    input  logic [WIDTH-1:0] operand_a,
    input  logic [WIDTH-1:0] operand_b,
    input  logic [1:0]       shift_mode,
    output logic [WIDTH-1:0] result
);

    localparam int unsigned STAGES = $clog2(WIDTH);

    shift_ctrl_t                   ctrl_d;
    logic [STAGES:0][WIDTH-1:0]    stage_d;
    logic [WIDTH-1:0]              post_d;

    always_comb begin
        ctrl_d         = '0;
        ctrl_d.reverse = shift_mode[0];
        ctrl_d.fill    = (shift_mode == MODE_SHR_ART) ? operand_a[WIDTH-1] : 1'b0;
    end

    bit_reverse_stage #(.WIDTH(WIDTH)) u_pre_rev (
        .enable   (ctrl_d.reverse),
        .data_in  (operand_a),
        .data_out (stage_d[0])
    );

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        left_shift_stage #(.WIDTH(WIDTH), .DIST(1 << s)) u_shl (
            .enable   (operand_b[s]),
            .fill     (ctrl_d.fill),
            .data_in  (stage_d[s]),
            .data_out (stage_d[s+1])
        );
    end

    bit_reverse_stage #(.WIDTH(WIDTH)) u_post_rev (
        .enable   (ctrl_d.reverse),
        .data_in  (stage_d[STAGES]),
        .data_out (post_d)
    );

    assign result = post_d;

endmodule

// File: rtl/reversing_shifter_chk.sv
module reversing_shifter_chk #(
    parameter int unsigned WIDTH = 16
) (
    input logic [WIDTH-1:0] operand_a,
    input logic [WIDTH-1:0] operand_b,
    input logic [1:0]       shift_mode,
    input logic [WIDTH-1:0] result
);

    always_comb begin
        if (operand_b[3:0] == 4'd0) begin
            assert_zero_count_identity_R5: assert (result == operand_a);
        end
        if (shift_mode == 2'b11 && operand_b[3:0] != 4'd0) begin
            assert_sign_kept_R3: assert (result[WIDTH-1] == operand_a[WIDTH-1]);
        end
        if (shift_mode == 2'b01 && operand_b[3:0] != 4'd0) begin
            assert_zero_top_R2: assert (result[WIDTH-1] == 1'b0);
        end
        if (!shift_mode[0] && operand_b[3:0] != 4'd0) begin
            assert_zero_bottom_R1: assert (result[0] == 1'b0);
        end
        if (shift_mode == 2'b11 && operand_b[3:0] == 4'd15) begin
            assert_full_sign_R6: assert (result == {WIDTH{operand_a[WIDTH-1]}});
        end
    end

endmodule

bind reversing_shifter reversing_shifter_chk #(.WIDTH(WIDTH)) u_chk (
    .operand_a  (operand_a),
    .operand_b  (operand_b),
    .shift_mode (shift_mode),
    .result     (result)
);

// File: tb/reversing_shifter_test.sv
module reversing_shifter_test;

    localparam int CLK_PERIOD = 10;
    localparam int N_PAT      = 40;

    logic        clk = 1'b0;
    logic [15:0] operand_a;
    logic [15:0] operand_b;
    logic [1:0]  shift_mode;
    logic [15:0] result;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reversing_shifter uut (
        .operand_a  (operand_a),
        .operand_b  (operand_b),
        .shift_mode (shift_mode),
        .result     (result)
    );

    function automatic logic [15:0] pattern(input int k);
        logic [15:0] v;
        case (k)
            0: v = 16'h0000;
            1: v = 16'hFFFF;
            2: v = 16'h8000;
            3: v = 16'h0001;
            4: v = 16'hAAAA;
            5: v = 16'h5555;
            6: v = 16'h7FFF;
            7: v = 16'h8001;
            default: v = 16'(k * 40503 + 12345) ^ 16'(k << 9);
        endcase
        return v;
    endfunction

    function automatic logic [15:0] expect_val(input logic [15:0] a, input logic [3:0] n,
                                               input logic [1:0] m);
        logic [15:0] e;
        case (m)
            2'b01:   e = a >> n;
            2'b11:   e = 16'($signed(a) >>> n);
            default: e = a << n;
        endcase
        return e;
    endfunction

    task automatic check(input string req, input logic [15:0] exp);
        checks++;
        if (result !== exp) begin
            fails++;
            $display("FAIL %s a=%h b=%h mode=%b actual=%h expected=%h",
                     req, operand_a, operand_b, shift_mode, result, exp);
        end
    endtask

    task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic [1:0] m);
        @(negedge clk);
        operand_a  = a;
        operand_b  = b;
        shift_mode = m;
        #1;
    endtask

    initial begin
        operand_a  = '0;
        operand_b  = '0;
        shift_mode = 2'b00;
        #1;
        check("R5 initial zero", 16'h0000);

        for (int m = 0; m < 4; m++) begin
            for (int n = 0; n < 16; n++) begin
                for (int k = 0; k < N_PAT; k++) begin
                    logic [15:0] a;
                    logic [15:0] b;
                    a = pattern(k);
                    b = {12'h000, 4'(n)};
                    apply(a, b, 2'(m));
                    if (n == 0)      check("R5", a);
                    else if (m == 1) check("R2", expect_val(a, 4'(n), 2'b01));
                    else if (m == 3) check("R3", expect_val(a, 4'(n), 2'b11));
                    else if (m == 2) check("R7", a << n);
                    else             check("R1", expect_val(a, 4'(n), 2'b00));
                    if (m == 3 && n == 15) check("R6", {16{a[15]}});
                    b = {12'(k * 2654 + n * 77 + m * 911 + 1), 4'(n)};
                    apply(a, b, 2'(m));
                    check("R4", expect_val(a, 4'(n), 2'(m)));
                end
            end
        end

        operand_a  = 16'h8421;
        operand_b  = 16'h0003;
        shift_mode = 2'b11;
        #1;
        check("R8 no clock edge", 16'hF084);
        operand_b  = 16'h0004;
        #1;
        check("R8 no clock edge", 16'hF842);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule